// File: doc/BRIEF.md
# Pending Interrupt Preemption Arbiter

This block sits inside a CPU interrupt interface and answers one question for each interrupt domain: which pending interrupt, if any, is allowed to preempt the work the core is doing now? Two candidates compete for each domain. One is the best private peripheral interrupt that the interface tracks locally. The other is the best interrupt that an external routing service has forwarded to this core. Each candidate carries an ID, a type and a priority.

The winner must pass two tests before it is reported. Its priority must be within the domain's priority mask. It must also be strictly more urgent than the running priority, which comes from the domain's active-priorities bitmap. The answer is packed into a 64-bit status word and refreshed every cycle. There is one status word for each domain.

Software reads the status word through two paths. The logical-domain read path returns the word of the domain named by `domainSel`. The top-domain read path always returns the word of the most privileged domain, which is the highest domain index.

Top module: `irq_preempt_arb`

## Requirements
- R1: Priorities are 5-bit values where a smaller number is more urgent. Candidate priority inputs are 6 bits wide. A candidate whose priority is 32 or higher is treated as absent, whatever its ID and type inputs hold.
- R2: The status word layout for a reported interrupt is as follows. Bits [23:0] hold the winner's ID. Bits [31:29] hold its 3-bit type. Bit 32 is the valid flag and is set to 1.
- R3: When a domain's enable bit is 0, that domain's status word is all zeros.
- R4: When both candidates are present with equal priority, the local peripheral candidate wins. Otherwise the present candidate with the smaller priority value wins.
- R5: The winner is reported only if its priority value is less than or equal to the domain's 5-bit priority mask.
- R6: The running priority is the index of the lowest set bit in the domain's 32-bit active bitmap, or 32 when no bit is set. The winner is reported only if its priority value is strictly below the running priority.
- R7: When no candidate qualifies, the whole status word reads as zero: ID zero, type zero and valid flag clear.
- R8: Bits [28:24] and [63:33] of any value on `rdData` are always zero.
- R9: Each status word is registered, so it reflects the inputs as they stood one clock earlier. A read strobe loads `rdData` at the next edge. `rdValid` is high for exactly the cycle after a strobe. Between reads, `rdData` holds its value.
- R10: `rdStrobe` returns the word of the domain given by `domainSel` at the strobe. `rdTopStrobe` returns the word of the highest-index domain. If both strobes are high together, the top-domain word is returned.
- R11: Domains are independent. The inputs of one domain never change the word of another.
- R12: After reset, `rdData` is zero and `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| domainSel | input | 1 | Current logical domain for the logical read path |
| ifEnable | input | 2 | Interface enable, one bit per domain |
| prioMask | input | 10 | 5-bit priority mask per domain |
| activeBits | input | 64 | 32-bit active-priorities bitmap per domain |
| localId | input | 48 | Local candidate ID, 24 bits per domain |
| localType | input | 6 | Local candidate type, 3 bits per domain |
| localPrio | input | 12 | Local candidate priority, 6 bits per domain (32 or more means absent) |
| remoteId | input | 48 | Forwarded candidate ID, 24 bits per domain |
| remoteType | input | 6 | Forwarded candidate type, 3 bits per domain |
| remotePrio | input | 12 | Forwarded candidate priority, 6 bits per domain (32 or more means absent) |
| rdStrobe | input | 1 | Read request on the logical-domain path |
| rdTopStrobe | input | 1 | Read request on the top-domain path |
| rdData | output | 64 | Status word returned by the last read |
| rdValid | output | 1 | High for one cycle when `rdData` has been loaded |

## Verification
The bench builds the block with its default parameters: a 24-bit ID, 5-bit priorities and two domains. With these values the idle priority (32) and the extreme bits of the bitmap, 0 and 31, can be driven directly. The two domains let the bench compare the logical read path against the fixed top-domain path while the domains hold different settings. The bench also drives all-ones IDs and types to show that the reserved bits stay clear.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Field positions that software decodes in the status word.
  localparam int TYPE_LSB  = 29;
  localparam int VALID_BIT = 32;

  // Strobes passed from the control block to the datapath.
  typedef struct packed {
    logic capture;  // load rdData at the next edge
    logic pickTop;  // use the top-domain word instead of the logical one
  } arbStrobe_t;

endpackage

// File: rtl/irq_run_prio.sv
module irq_run_prio #(
  parameter int PRIO_W = 5
) (
  input  logic [(1<<PRIO_W)-1:0] activeMap,
  output logic [PRIO_W:0]        runPrio
);
  localparam int NUM_PRIO = 1 << PRIO_W;

  // Scan from the top down, so the lowest set bit is the last one written.
  always_comb begin
    runPrio = (PRIO_W+1)'(NUM_PRIO);
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (activeMap[i]) runPrio = (PRIO_W+1)'(i);
    end
  end
endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdStrobe,
  input  logic       rdTopStrobe,
  output arbStrobe_t strobes,
  output logic       rdValid
);
  always_comb begin
    strobes.capture = rdStrobe | rdTopStrobe;
    strobes.pickTop = rdTopStrobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdValid <= 1'b0;
    else        rdValid <= strobes.capture;
  end
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int ID_W    = 24,
  parameter int TYPE_W  = 3,
  parameter int PRIO_W  = 5,
  parameter int NUM_DOM = 2,
  parameter int WORD_W  = 64,
  parameter int DOM_W   = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DOM_W-1:0]                domainSel,
  input  logic [NUM_DOM-1:0]              ifEnable,
  input  logic [NUM_DOM*PRIO_W-1:0]       prioMask,
  input  logic [NUM_DOM*(1<<PRIO_W)-1:0]  activeBits,
  input  logic [NUM_DOM*ID_W-1:0]         localId,
  input  logic [NUM_DOM*TYPE_W-1:0]       localType,
  input  logic [NUM_DOM*(PRIO_W+1)-1:0]   localPrio,
  input  logic [NUM_DOM*ID_W-1:0]         remoteId,
  input  logic [NUM_DOM*TYPE_W-1:0]       remoteType,
  input  logic [NUM_DOM*(PRIO_W+1)-1:0]   remotePrio,
  input  arbStrobe_t                      strobes,
  output logic [WORD_W-1:0]               rdData
);
  localparam int PW1      = PRIO_W + 1;
  localparam int NUM_PRIO = 1 << PRIO_W;
  localparam logic [PW1-1:0] IDLE = PW1'(NUM_PRIO);

  logic [WORD_W-1:0] statusReg [NUM_DOM];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [PW1-1:0]    lPrio, rPrio, winPrio, runPrio;
    logic [ID_W-1:0]   winId;
    logic [TYPE_W-1:0] winType;
    logic              lHere, rHere, pickLocal, qualify;
    logic [WORD_W-1:0] wordNext;

    assign lPrio = localPrio[d*PW1 +: PW1];
    assign rPrio = remotePrio[d*PW1 +: PW1];

    irq_run_prio #(.PRIO_W(PRIO_W)) u_run (
      .activeMap(activeBits[d*NUM_PRIO +: NUM_PRIO]),
      .runPrio  (runPrio)
    );

    always_comb begin
      lHere     = lPrio < IDLE;
      rHere     = rPrio < IDLE;
      pickLocal = lHere && (!rHere || lPrio <= rPrio);
      winPrio   = pickLocal ? lPrio : (rHere ? rPrio : IDLE);
      winId     = pickLocal ? localId[d*ID_W +: ID_W] : remoteId[d*ID_W +: ID_W];
      winType   = pickLocal ? localType[d*TYPE_W +: TYPE_W]
                            : remoteType[d*TYPE_W +: TYPE_W];
      qualify   = ifEnable[d] && (lHere || rHere)
                  && (winPrio <= {1'b0, prioMask[d*PRIO_W +: PRIO_W]})
                  && (winPrio < runPrio);
      wordNext  = '0;
      if (qualify) begin
        wordNext[ID_W-1:0]                 = winId;
        wordNext[TYPE_LSB +: TYPE_W]       = winType;
        wordNext[VALID_BIT]                = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) statusReg[d] <= '0;
      else        statusReg[d] <= wordNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else if (strobes.capture)
      rdData <= strobes.pickTop ? statusReg[NUM_DOM-1] : statusReg[domainSel];
  end
endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb
  import irq_arb_pkg::*;
#(
  parameter int ID_W    = 24,
  parameter int TYPE_W  = 3,
  parameter int PRIO_W  = 5,
  parameter int NUM_DOM = 2,
  parameter int WORD_W  = 64,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DOM_W-1:0]                domainSel,
  input  logic [NUM_DOM-1:0]              ifEnable,
  input  logic [NUM_DOM*PRIO_W-1:0]       prioMask,
  input  logic [NUM_DOM*(1<<PRIO_W)-1:0]  activeBits,
  input  logic [NUM_DOM*ID_W-1:0]         localId,
  input  logic [NUM_DOM*TYPE_W-1:0]       localType,
  input  logic [NUM_DOM*(PRIO_W+1)-1:0]   localPrio,
  input  logic [NUM_DOM*ID_W-1:0]         remoteId,
  input  logic [NUM_DOM*TYPE_W-1:0]       remoteType,
  input  logic [NUM_DOM*(PRIO_W+1)-1:0]   remotePrio,
  input  logic                            rdStrobe,
  input  logic                            rdTopStrobe,
  output logic [WORD_W-1:0]               rdData,
  output logic                            rdValid
);
  arbStrobe_t strobes;

  irq_arb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdStrobe   (rdStrobe),
    .rdTopStrobe(rdTopStrobe),
    .strobes    (strobes),
    .rdValid    (rdValid)
  );

  irq_arb_datapath #(
    .ID_W(ID_W), .TYPE_W(TYPE_W), .PRIO_W(PRIO_W),
    .NUM_DOM(NUM_DOM), .WORD_W(WORD_W), .DOM_W(DOM_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .domainSel (domainSel),
    .ifEnable  (ifEnable),
    .prioMask  (prioMask),
    .activeBits(activeBits),
    .localId   (localId),
    .localType (localType),
    .localPrio (localPrio),
    .remoteId  (remoteId),
    .remoteType(remoteType),
    .remotePrio(remotePrio),
    .strobes   (strobes),
    .rdData    (rdData)
  );
endmodule

// File: rtl/irq_preempt_arb_chk.sv
module irq_preempt_arb_chk #(
  parameter int NUM_DOM = 2,
  parameter int WORD_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DOM-1:0] ifEnable,
  input logic               rdStrobe,
  input logic               rdTopStrobe,
  input logic [WORD_W-1:0]  rdData,
  input logic               rdValid
);
  // R8: reserved bits never set
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[28:24] == '0) && (rdData[WORD_W-1:33] == '0));

  // R7: a word without the valid flag is entirely zero
  assert_invalid_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdData[32] |-> rdData == '0);

  // R9: rdValid follows a strobe by exactly one cycle
  assert_valid_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe || rdTopStrobe) |=> rdValid);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdStrobe || rdTopStrobe) |=> !rdValid);

  // R3: a top-domain read of a disabled domain returns zero
  assert_disabled_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rdTopStrobe) && !$past(ifEnable[NUM_DOM-1], 2)) |-> rdData == '0);
endmodule

bind irq_preempt_arb irq_preempt_arb_chk #(.NUM_DOM(NUM_DOM), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ifEnable   (ifEnable),
  .rdStrobe   (rdStrobe),
  .rdTopStrobe(rdTopStrobe),
  .rdData     (rdData),
  .rdValid    (rdValid)
);

// File: tb/test_irq_preempt_arb.sv
module test_irq_preempt_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        domainSel = 1'b0;
  logic [1:0]  ifEnable;
  logic [9:0]  prioMask;
  logic [63:0] activeBits;
  logic [47:0] localId, remoteId;
  logic [5:0]  localType, remoteType;
  logic [11:0] localPrio, remotePrio;
  logic        rdStrobe = 1'b0, rdTopStrobe = 1'b0;
  logic [63:0] rdData;
  logic        rdValid;

  int checks = 0, fails = 0;
  bit done = 0;

  // Model state for each domain
  bit          en [2];
  int          msk [2];
  logic [31:0] act [2];
  int          lid [2], lty [2], lpr [2], rid [2], rty [2], rpr [2];

  always #5 clk = ~clk;

  irq_preempt_arb i_irq_preempt_arb (
    .clk(clk), .rst_n(rst_n), .domainSel(domainSel), .ifEnable(ifEnable),
    .prioMask(prioMask), .activeBits(activeBits), .localId(localId),
    .localType(localType), .localPrio(localPrio), .remoteId(remoteId),
    .remoteType(remoteType), .remotePrio(remotePrio), .rdStrobe(rdStrobe),
    .rdTopStrobe(rdTopStrobe), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [63:0] expect_word(int d);
    int run = 32;
    bit lok, rok, pickL;
    int wp, wid, wty;
    logic [63:0] w = '0;
    for (int i = 31; i >= 0; i--) if (act[d][i]) run = i;
    lok = lpr[d] < 32;
    rok = rpr[d] < 32;
    pickL = lok && (!rok || lpr[d] <= rpr[d]);
    wp  = pickL ? lpr[d] : rpr[d];
    wid = pickL ? lid[d] : rid[d];
    wty = pickL ? lty[d] : rty[d];
    if (en[d] && (lok || rok) && wp <= msk[d] && wp < run) begin
      w[23:0]  = wid[23:0];
      w[31:29] = wty[2:0];
      w[32]    = 1'b1;
    end
    return w;
  endfunction

  task automatic drive();
    for (int d = 0; d < 2; d++) begin
      ifEnable[d]          = en[d];
      prioMask[d*5 +: 5]   = msk[d][4:0];
      activeBits[d*32 +: 32] = act[d];
      localId[d*24 +: 24]  = lid[d][23:0];
      localType[d*3 +: 3]  = lty[d][2:0];
      localPrio[d*6 +: 6]  = lpr[d][5:0];
      remoteId[d*24 +: 24] = rid[d][23:0];
      remoteType[d*3 +: 3] = rty[d][2:0];
      remotePrio[d*6 +: 6] = rpr[d][5:0];
    end
  endtask

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_dom(int d, bit e, int m, logic [31:0] a,
                         int li, int lt, int lp, int ri, int rt, int rp);
    en[d] = e; msk[d] = m; act[d] = a;
    lid[d] = li; lty[d] = lt; lpr[d] = lp;
    rid[d] = ri; rty[d] = rt; rpr[d] = rp;
  endtask

  // Apply inputs at a falling edge, let the status word register, then read.
  task automatic read_and_check(string req, bit logical, bit top, bit sel, int expDom);
    @(negedge clk);
    drive();
    @(posedge clk);
    @(negedge clk);
    domainSel = sel; rdStrobe = logical; rdTopStrobe = top;
    @(posedge clk);
    @(negedge clk);
    rdStrobe = 0; rdTopStrobe = 0;
    check(req, rdData, expect_word(expDom));
    check({req, " valid"}, {63'b0, rdValid}, 64'd1);
  endtask

  task automatic t_reset();
    check("R12 data", rdData, '0);
    check("R12 valid", {63'b0, rdValid}, '0);
  endtask

  task automatic t_select();
    set_dom(0, 1, 31, 0, 'h123456, 3, 5, 'h0ABCDE, 6, 9);
    read_and_check("R2 R4 local lower", 1, 0, 0, 0);
    check("R2 layout", rdData, 64'h1_6012_3456);
    set_dom(0, 1, 31, 0, 'h123456, 3, 12, 'h0ABCDE, 6, 4);
    read_and_check("R4 remote lower", 1, 0, 0, 0);
    set_dom(0, 1, 31, 0, 'h111111, 1, 7, 'h222222, 2, 7);
    read_and_check("R4 tie local", 1, 0, 0, 0);
    check("R4 tie id", {40'b0, rdData[23:0]}, 64'h111111);
  endtask

  task automatic t_mask();
    set_dom(0, 1, 10, 0, 'h000AAA, 2, 10, 0, 0, 32);
    read_and_check("R5 equal mask", 1, 0, 0, 0);
    check("R5 equal reported", {63'b0, rdData[32]}, 64'd1);
    set_dom(0, 1, 10, 0, 'h000AAA, 2, 11, 0, 0, 32);
    read_and_check("R5 above mask", 1, 0, 0, 0);
    check("R5 above zero", rdData, '0);
  endtask

  task automatic t_running();
    set_dom(0, 1, 31, 32'h0000_1080, 'h00BEEF, 1, 7, 0, 0, 40);
    read_and_check("R6 equal running", 1, 0, 0, 0);
    check("R6 equal blocked", rdData, '0);
    set_dom(0, 1, 31, 32'h0000_1080, 'h00BEEF, 1, 6, 0, 0, 40);
    read_and_check("R6 below running", 1, 0, 0, 0);
    check("R6 below reported", {63'b0, rdData[32]}, 64'd1);
    set_dom(0, 1, 31, 32'h8000_0000, 0, 0, 32, 'h00C0DE, 5, 30);
    read_and_check("R6 bit31 R1 absent local", 1, 0, 0, 0);
    set_dom(0, 1, 31, 32'h0000_0001, 'h000001, 1, 0, 0, 0, 32);
    read_and_check("R6 bit0 blocks all", 1, 0, 0, 0);
    set_dom(0, 1, 31, 0, 'h000002, 4, 31, 0, 0, 32);
    read_and_check("R6 empty bitmap", 1, 0, 0, 0);
  endtask

  task automatic t_disable_idle();
    set_dom(0, 0, 31, 0, 'h123456, 3, 1, 'h654321, 2, 2);
    read_and_check("R3 disabled", 1, 0, 0, 0);
    check("R3 zero", rdData, '0);
    set_dom(0, 1, 31, 0, 'hFFFFFF, 7, 32, 'hFFFFFF, 7, 63);
    read_and_check("R1 R7 both absent", 1, 0, 0, 0);
    check("R7 zero", rdData, '0);
  endtask

  task automatic t_reserved();
    set_dom(0, 1, 31, 0, 'hFFFFFF, 7, 0, 0, 0, 32);
    read_and_check("R8 all ones", 1, 0, 0, 0);
    check("R8 reserved", rdData & ~64'h1_E0FF_FFFF, '0);
  endtask

  task automatic t_banked();
    set_dom(0, 1, 31, 0, 'h0000D0, 1, 3, 0, 0, 32);
    set_dom(1, 1, 31, 0, 'h0000D1, 2, 4, 0, 0, 32);
    read_and_check("R10 R11 logical dom0", 1, 0, 0, 0);
    read_and_check("R10 R11 logical dom1", 1, 0, 1, 1);
    read_and_check("R10 top path", 0, 1, 0, 1);
    read_and_check("R10 both strobes top", 1, 1, 0, 1);
    set_dom(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    read_and_check("R11 dom0 unaffected", 1, 0, 0, 0);
    check("R11 dom0 id", {40'b0, rdData[23:0]}, 64'hD0);
  endtask

  task automatic t_timing();
    logic [63:0] oldWord;
    set_dom(0, 1, 31, 0, 'h000111, 1, 2, 0, 0, 32);
    read_and_check("R9 setup", 1, 0, 0, 0);
    oldWord = rdData;
    @(negedge clk);
    check("R9 valid drops", {63'b0, rdValid}, '0);
    check("R9 data holds", rdData, oldWord);
    // change inputs and strobe together: the read returns the previous word
    set_dom(0, 1, 31, 0, 'h000222, 1, 2, 0, 0, 32);
    drive();
    rdStrobe = 1;
    @(posedge clk);
    @(negedge clk);
    rdStrobe = 0;
    check("R9 registered old", rdData, oldWord);
    rdStrobe = 1;
    @(posedge clk);
    @(negedge clk);
    rdStrobe = 0;
    check("R9 registered new", rdData, expect_word(0));
  endtask

  initial begin
    for (int d = 0; d < 2; d++) set_dom(d, 0, 0, 0, 0, 0, 32, 0, 0, 32);
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_select();
    t_mask();
    t_running();
    t_disable_idle();
    t_reserved();
    t_banked();
    t_timing();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule